// File: doc/BRIEF.md
# Thermal Shutdown State Controller

This block sits on the logic side of a bus transceiver. Each cycle it compares a digitized junction-temperature proxy with a programmable trip level. It decides whether the transmit path may follow the local TxD input or must be held recessive. Once the block is hot, it holds the transmitter off until two gates are both met. The first gate is a temperature drop below a recovery level, which is the trip level minus a programmable hysteresis. The second is an unbroken cooldown interval. A mode input selects how the block returns to normal: by itself, or only after a host clear.

A separate watchdog looks at TxD. If TxD is held dominant for too long, the watchdog raises its own flag and forces the line recessive until TxD is released. This fault never touches the thermal flag. A saturating counter records every entry into shutdown, so a host can see heat-driven oscillation. The receive path passes straight through in every state.

Top module: `thermal_guard`

## Requirements
- R1: After reset, state_code is 0 (normal), both flags are 0, trip_count is 0 and tx_out follows txd.
- R2: In normal state (code 0), a temp_in value at or above trip_level moves the block to shutdown (code 1) at the next clock edge. A lower value keeps it in normal.
- R3: In shutdown, the block moves to cooldown (code 2) at the next edge only when temp_in is strictly below trip_level minus hyst_delta. If hyst_delta is at least trip_level, the recovery level is 0 and the block never leaves shutdown.
- R4: If temp_in stays below the recovery level, cooldown lasts exactly cool_len cycles, with 0 treated as 1. The block then goes to normal when latch_mode is 0, or to latched (code 3) when latch_mode is 1.
- R5: The latched state holds until host_clear is sampled high, and then returns to normal at that edge. In other states, host_clear has no effect on the state.
- R6: During cooldown, temp_in at or above the recovery level sends the block back to shutdown at the next edge. This takes priority over cooldown completion. The next cooldown starts its full interval again.
- R7: tx_out is 1 (recessive) in every state other than normal. In normal state, with no timeout pending, tx_out equals txd.
- R8: txd=0 is dominant. When txd has been sampled 0 on dom_limit+1 consecutive edges, dom_flag rises and tx_out is held at 1. dom_flag clears at the first edge that samples txd=1.
- R9: thermal_flag is 1 exactly when state_code is not 0. A dominant timeout never sets thermal_flag.
- R10: trip_count increments on every entry into shutdown, whether from normal or from cooldown. It saturates at its all-ones value. Any sampled host_clear sets it to 0, and the clear wins over a same-edge increment.
- R11: rxd equals bus_rx in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_in | input | TEMP_W | Junction-temperature proxy code |
| trip_level | input | TEMP_W | Shutdown threshold |
| hyst_delta | input | TEMP_W | Recovery hysteresis below the trip level |
| cool_len | input | COOL_W | Cooldown length in cycles |
| dom_limit | input | DOM_W | Dominant cycles allowed before the timeout |
| latch_mode | input | 1 | 1 selects latched recovery, 0 selects auto-retry |
| host_clear | input | 1 | Host clear pulse |
| txd | input | 1 | Local transmit data, 0 is dominant |
| bus_rx | input | 1 | Receive data from the line |
| tx_out | output | 1 | Transmit drive, 1 is recessive |
| rxd | output | 1 | Receive data to the controller |
| thermal_flag | output | 1 | Thermal fault active |
| dom_flag | output | 1 | Dominant-timeout fault active |
| state_code | output | 2 | 0 normal, 1 shutdown, 2 cooldown, 3 latched |
| trip_count | output | CNT_W | Saturating count of shutdown entries |

## Verification
The bench builds the block with a 6-bit temperature, a 4-bit cooldown timer, a 4-bit timeout counter and a 2-bit trip counter. With these widths, every temperature code can be swept against the trip and recovery thresholds. Every cooldown length from 1 to 15 can be timed cycle by cycle. The trip counter reaches saturation after only three entries. The same small widths also let a range of timeout limits, including 0, be measured to the exact cycle.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL   = 2'd0,
      ST_SHUTDOWN = 2'd1,
      ST_COOLDOWN = 2'd2,
      ST_LATCHED  = 2'd3
   } tg_state_e;
endpackage

// File: rtl/tg_cool_timer.sv
module tg_cool_timer #(
   parameter int COOL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [COOL_W-1:0] len,
   output logic              done
);
   logic [COOL_W-1:0] cnt;
   logic [COOL_W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt} + {{COOL_W{1'b0}}, 1'b1};
   // a zero length behaves as a single cycle
   assign done    = run && (cnt_nxt >= {1'b0, len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (!cnt_nxt[COOL_W]) cnt <= cnt_nxt[COOL_W-1:0];
   end
endmodule

// File: rtl/tg_dom_timer.sv
module tg_dom_timer #(
   parameter int DOM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txd,
   input  logic [DOM_W-1:0] limit,
   output logic             flag
);
   logic [DOM_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (txd) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (~&cnt)         cnt  <= cnt + 1'b1;
         if (cnt >= limit)  flag <= 1'b1;
      end
   end
endmodule

// File: rtl/tg_trip_counter.sv
module tg_trip_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (inc && ~&count)   count <= count + 1'b1;
   end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
   import thermal_guard_pkg::*;
#(
   parameter int TEMP_W = 8,
   parameter int COOL_W = 16,
   parameter int DOM_W  = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_in,
   input  logic [TEMP_W-1:0] trip_level,
   input  logic [TEMP_W-1:0] hyst_delta,
   input  logic [COOL_W-1:0] cool_len,
   input  logic [DOM_W-1:0]  dom_limit,
   input  logic              latch_mode,
   input  logic              host_clear,
   input  logic              txd,
   input  logic              bus_rx,
   output logic              tx_out,
   output logic              rxd,
   output logic              thermal_flag,
   output logic              dom_flag,
   output logic [1:0]        state_code,
   output logic [CNT_W-1:0]  trip_count
);
   generate
      if (TEMP_W < 2 || TEMP_W > 32) begin : g_bad_temp
         $error("thermal_guard: TEMP_W out of range");
      end
      if (COOL_W < 1 || COOL_W > 32) begin : g_bad_cool
         $error("thermal_guard: COOL_W out of range");
      end
      if (DOM_W < 1 || DOM_W > 32) begin : g_bad_dom
         $error("thermal_guard: DOM_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("thermal_guard: CNT_W out of range");
      end
   endgenerate

   tg_state_e         st, st_nxt;
   logic [TEMP_W-1:0] rec_level;
   logic              is_hot, is_cold, cool_done, trip_inc;

   assign rec_level = (trip_level > hyst_delta) ? (trip_level - hyst_delta) : '0;
   assign is_hot    = (temp_in >= trip_level);
   assign is_cold   = (temp_in < rec_level);

   always_comb begin
      st_nxt   = st;
      trip_inc = 1'b0;
      unique case (st)
         ST_NORMAL: if (is_hot) begin
            st_nxt   = ST_SHUTDOWN;
            trip_inc = 1'b1;
         end
         ST_SHUTDOWN: if (is_cold) st_nxt = ST_COOLDOWN;
         ST_COOLDOWN: begin
            if (!is_cold) begin
               st_nxt   = ST_SHUTDOWN;
               trip_inc = 1'b1;
            end else if (cool_done) begin
               st_nxt = latch_mode ? ST_LATCHED : ST_NORMAL;
            end
         end
         ST_LATCHED: if (host_clear) st_nxt = ST_NORMAL;
         default: st_nxt = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_NORMAL;
      else        st <= st_nxt;
   end

   tg_cool_timer #(.COOL_W(COOL_W)) u_cool (
      .clk   (clk),
      .rst_n (rst_n),
      .run   ((st == ST_COOLDOWN) && is_cold),
      .len   (cool_len),
      .done  (cool_done)
   );

   tg_dom_timer #(.DOM_W(DOM_W)) u_dom (
      .clk   (clk),
      .rst_n (rst_n),
      .txd   (txd),
      .limit (dom_limit),
      .flag  (dom_flag)
   );

   tg_trip_counter #(.CNT_W(CNT_W)) u_trips (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (trip_inc),
      .clr   (host_clear),
      .count (trip_count)
   );

   assign thermal_flag = (st != ST_NORMAL);
   assign state_code   = st;
   assign tx_out       = (st == ST_NORMAL && !dom_flag) ? txd : 1'b1;
   assign rxd          = bus_rx;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
   parameter int TEMP_W = 8,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TEMP_W-1:0] temp_in,
   input logic [TEMP_W-1:0] trip_level,
   input logic [TEMP_W-1:0] hyst_delta,
   input logic              host_clear,
   input logic              txd,
   input logic              tx_out,
   input logic              dom_flag,
   input logic [1:0]        state_code,
   input logic [CNT_W-1:0]  trip_count
);
   logic [TEMP_W-1:0] rec_c;
   assign rec_c = (hyst_delta >= trip_level) ? '0 : trip_level - hyst_delta;

   AST_TRIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd0 && temp_in >= trip_level) |=> state_code == 2'd1); // R2

   AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd1 && temp_in >= rec_c) |=> state_code == 2'd1); // R3

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd3 && !host_clear) |=> state_code == 2'd3); // R5

   AST_REHEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd2 && temp_in >= rec_c) |=> state_code == 2'd1); // R6

   AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code != 2'd0 || dom_flag) |-> tx_out); // R7

   AST_DOM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      txd |=> !dom_flag); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&trip_count && !host_clear) |=> &trip_count); // R10
endmodule

bind thermal_guard tg_checker #(.TEMP_W(TEMP_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .temp_in    (temp_in),
   .trip_level (trip_level),
   .hyst_delta (hyst_delta),
   .host_clear (host_clear),
   .txd        (txd),
   .tx_out     (tx_out),
   .dom_flag   (dom_flag),
   .state_code (state_code),
   .trip_count (trip_count)
);

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
   localparam int TW = 6, CW = 4, DW = 4, NW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] temp_in = '0, trip_level = 6'd40, hyst_delta = 6'd5;
   logic [CW-1:0] cool_len = 4'd15;
   logic [DW-1:0] dom_limit = 4'd15;
   logic latch_mode = 1'b0, host_clear = 1'b0, txd = 1'b1, bus_rx = 1'b1;
   logic tx_out, rxd, thermal_flag, dom_flag;
   logic [1:0] state_code;
   logic [NW-1:0] trip_count;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   thermal_guard #(.TEMP_W(TW), .COOL_W(CW), .DOM_W(DW), .CNT_W(NW)) u0 (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      // R1 reset values
      chk(state_code == 2'd0 && !thermal_flag && !dom_flag && trip_count == 0,
          "R1 reset", state_code, 0);
      txd = 1'b0; #1;
      chk(tx_out == 1'b0, "R1 tx follows", tx_out, 0);
      txd = 1'b1; #1;

      // R2 trip sweep
      for (int t = 0; t < 64; t++) begin
         do_reset();
         temp_in = t[TW-1:0];
         tick();
         chk(state_code == ((t >= 40) ? 2'd1 : 2'd0), "R2 trip sweep", state_code, (t >= 40) ? 1 : 0);
         chk(thermal_flag == (t >= 40), "R9 thermal flag", thermal_flag, (t >= 40) ? 1 : 0);
      end

      // R3 recovery sweep, recovery level 35
      for (int t = 0; t < 64; t++) begin
         do_reset();
         temp_in = 6'd50; tick();
         temp_in = t[TW-1:0]; tick();
         chk(state_code == ((t < 35) ? 2'd2 : 2'd1), "R3 recovery sweep", state_code, (t < 35) ? 2 : 1);
      end
      // R3 hysteresis above trip level: no recovery at all
      do_reset();
      hyst_delta = 6'd45;
      temp_in = 6'd50; tick();
      temp_in = 6'd0; tick(); tick();
      chk(state_code == 2'd1, "R3 zero recovery level", state_code, 1);
      hyst_delta = 6'd5;

      // R4 cooldown length sweep, auto mode
      for (int len = 0; len < 16; len++) begin
         do_reset();
         cool_len = len[CW-1:0];
         temp_in = 6'd50; tick();
         temp_in = 6'd10; tick();
         n = 0;
         while (state_code == 2'd2 && n < 40) begin tick(); n++; end
         chk(n == ((len == 0) ? 1 : len), "R4 cooldown length", n, (len == 0) ? 1 : len);
         chk(state_code == 2'd0, "R4 auto return", state_code, 0);
      end

      // R5 latched mode
      do_reset();
      latch_mode = 1'b1; cool_len = 4'd3;
      temp_in = 6'd50; tick();
      temp_in = 6'd10; tick(); tick(); tick(); tick();
      chk(state_code == 2'd3, "R5 enter latched", state_code, 3);
      for (int i = 0; i < 10; i++) tick();
      chk(state_code == 2'd3, "R5 latched holds", state_code, 3);
      txd = 1'b0; #1;
      chk(tx_out == 1'b1, "R7 tx forced in latched", tx_out, 1);
      txd = 1'b1;
      host_clear = 1'b1; tick(); host_clear = 1'b0;
      chk(state_code == 2'd0, "R5 clear releases", state_code, 0);
      chk(trip_count == 0, "R10 clear zeroes count", trip_count, 0);
      latch_mode = 1'b0;

      // R5 host_clear ignored in shutdown
      temp_in = 6'd50; tick();
      host_clear = 1'b1; tick(); host_clear = 1'b0;
      chk(state_code == 2'd1, "R5 clear ignored in shutdown", state_code, 1);

      // R6 reheat during cooldown, then full restart of timer
      do_reset();
      cool_len = 4'd5;
      temp_in = 6'd50; tick();
      temp_in = 6'd10; tick(); tick(); tick();
      chk(state_code == 2'd2, "R6 in cooldown", state_code, 2);
      temp_in = 6'd36; tick();
      chk(state_code == 2'd1, "R6 reheat to shutdown", state_code, 1);
      chk(trip_count == 2, "R10 reentry counted", trip_count, 2);
      temp_in = 6'd10; tick();
      n = 0;
      while (state_code == 2'd2 && n < 40) begin tick(); n++; end
      chk(n == 5, "R6 timer restarted", n, 5);
      // R6 reheat wins over completion (length 1)
      cool_len = 4'd1;
      temp_in = 6'd50; tick();
      temp_in = 6'd10; tick();
      temp_in = 6'd35; tick();
      chk(state_code == 2'd1, "R6 reheat priority", state_code, 1);

      // R7 tx forcing
      txd = 1'b0; #1;
      chk(tx_out == 1'b1, "R7 tx forced in shutdown", tx_out, 1);
      txd = 1'b1;
      do_reset();
      txd = 1'b0; #1;
      chk(tx_out == 1'b0, "R7 tx follows in normal", tx_out, 0);
      txd = 1'b1; #1;

      // R8 dominant timeout sweep
      for (int d = 0; d < 10; d++) begin
         do_reset();
         dom_limit = d[DW-1:0];
         txd = 1'b0;
         n = 0;
         while (!dom_flag && n < 40) begin tick(); n++; end
         chk(n == d + 1, "R8 timeout cycles", n, d + 1);
         chk(tx_out == 1'b1, "R8 tx forced", tx_out, 1);
         chk(!thermal_flag && state_code == 2'd0, "R9 timeout not thermal", thermal_flag, 0);
         txd = 1'b1; tick();
         chk(!dom_flag && tx_out == 1'b1, "R8 release clears", dom_flag, 0);
      end
      dom_limit = 4'd15;

      // R9 both faults reported apart
      do_reset();
      dom_limit = 4'd2; txd = 1'b0; tick(); tick(); tick();
      temp_in = 6'd50; tick();
      chk(dom_flag && thermal_flag, "R9 both flags", {dom_flag, thermal_flag}, 3);
      txd = 1'b1; tick();
      chk(!dom_flag && thermal_flag, "R9 flags independent", {dom_flag, thermal_flag}, 1);
      dom_limit = 4'd15;

      // R10 saturation
      do_reset();
      cool_len = 4'd1;
      for (int k = 1; k <= 5; k++) begin
         temp_in = 6'd50; tick();
         chk(trip_count == ((k > 3) ? 3 : k), "R10 saturating count", trip_count, (k > 3) ? 3 : k);
         temp_in = 6'd10; tick(); tick();
      end
      temp_in = 6'd50; host_clear = 1'b1; tick(); host_clear = 1'b0;
      chk(trip_count == 0 && state_code == 2'd1, "R10 clear beats increment", trip_count, 0);

      // R11 rx passthrough in several states
      for (int s = 0; s < 4; s++) begin
         bus_rx = 1'b0; #1;
         chk(rxd == 1'b0, "R11 rx low", rxd, 0);
         bus_rx = 1'b1; #1;
         chk(rxd == 1'b1, "R11 rx high", rxd, 1);
         tick();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule